// File: doc/BRIEF.md
# Latency-Matrix Issue Interlock

This block sits at the issue stage of an in-order, single-issue pipeline. It decides whether the instruction presented this cycle can leave issue. The alternative is to hold it because one of its source registers is still being computed by an earlier instruction. Every register has a scoreboard entry. Each entry records the class of the unit that last wrote the register (FP ALU, load, integer) and a down-counter. The counter is loaded when the writer issues and then drops by one on every clock.

Each source operand of the issuing instruction carries a consumer class: FP ALU operation, store data, integer operation or branch. The number of empty cycles that must separate producer and consumer comes from a parameterised matrix indexed by the pair of producer class and consumer class. It is not one fixed load-use rule. While the block stalls, issue holds the instruction and the pipeline takes a bubble. The counters keep running, so a stall always drains by itself. A branch delay slot needs no support here, because the slot instruction is issued like any other.

Top module: `ilk_interlock`

## Requirements
- R1: An FP ALU result read by a later FP ALU operation holds that consumer for 3 stall cycles when the two are issued back to back. Producer class codes are 0 none, 1 FP ALU, 2 load, 3 integer. Consumer class codes are 0 FP ALU, 1 store data, 2 integer, 3 branch.
- R2: An FP ALU result read as store data holds the store for 2 stall cycles when issued back to back.
- R3: A load result read by an FP ALU operation, an integer operation or a branch holds the consumer for 1 stall cycle when issued back to back.
- R4: A load result read as store data causes no stall.
- R5: An integer result read by an integer operation or a branch holds the consumer for 1 stall cycle when issued back to back.
- R6: The stall output is high only while the issue valid input is high and at least one enabled source is still too close to its producer. If two sources both have a hazard, the instruction waits for the later of the two. A stalled instruction writes nothing into the scoreboard. No stall lasts more than 3 consecutive cycles. Source operand i uses bits [6i+5:6i] of the register bus, bits [2i+1:2i] of the class bus and bit i of the enable.
- R7: A newer write to a register replaces the older entry. The newer producer's class and age alone then decide the stall.
- R8: A synchronous active-high reset clears every entry, so no instruction issued after reset stalls on a write made before it.
- R9: A source whose enable bit is low never causes a stall, even when it names a register that is in flight.
- R10: Replaying the unscheduled scalar-add-to-vector loop (load, FP add, store, pointer decrement, branch, delay-slot no-op) takes 10 cycles per iteration. The rescheduled version (load, decrement, FP add, branch, store in the delay slot) takes 6 cycles.
- R11: Pairs outside the matrix cause no stall: FP ALU into integer or branch, and integer into FP ALU or store data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction is presented at issue |
| iss_src_en | input | NSRC | Per-source operand enable |
| iss_src_reg | input | NSRC*REG_W | Per-source register index |
| iss_src_cls | input | 2*NSRC | Per-source consumer class |
| iss_wr_en | input | 1 | Instruction writes a destination |
| iss_dst | input | REG_W | Destination register index |
| iss_dst_cls | input | 2 | Producer class of the destination |
| iss_stall | output | 1 | Hold the instruction this cycle |

## Verification
Back-to-back producer and consumer pairs are tried for every matrix entry, together with the unlisted pairs. This separates a correct matrix lookup from a single shared latency or from swapped classes. Two-source instructions with hazards of unequal length test that the stall is the OR of the sources and not the first source alone. A write, then a quick rewrite of the same register by a faster producer, tells replacement apart from keeping the older entry. A disabled operand and a reset during a hazard tell ignoring apart from stale blocking. Both loop replays then check the whole cycle count per iteration, and a behavioural model of issue time is compared against the stall output on every clock.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

   typedef enum logic [1:0] {
      PC_NONE  = 2'd0,
      PC_FPALU = 2'd1,
      PC_LOAD  = 2'd2,
      PC_INT   = 2'd3
   } prod_cls_e;

   typedef enum logic [1:0] {
      CC_FPALU  = 2'd0,
      CC_STDATA = 2'd1,
      CC_INT    = 2'd2,
      CC_BRANCH = 2'd3
   } cons_cls_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ilk_sb_entry.sv
module ilk_sb_entry
   import ilk_pkg::*;
#(
   parameter int CNT_W = 2,
   parameter int LMAX  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  prod_cls_e        ld_cls,
   output prod_cls_e        cls_o,
   output logic [CNT_W-1:0] cnt_o
);

   prod_cls_e        cls_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         cls_q <= PC_NONE;
      end else if (ld) begin
         cnt_q <= CNT_W'(LMAX);
         cls_q <= ld_cls;
      end else if (cnt_q > CNT_W'(1)) begin
         cnt_q <= cnt_q - 1'b1;
      end else begin
         cnt_q <= '0;
         cls_q <= PC_NONE;
      end
   end

   assign cls_o = cls_q;
   assign cnt_o = cnt_q;

   // R8: reset empties the entry
   p_reset_clears_r8 : assert property (@(posedge clk)
      rst |=> (cnt_q == '0 && cls_q == PC_NONE));

   // R7: a new write replaces whatever was held
   p_load_replaces_r7 : assert property (@(posedge clk) disable iff (rst)
      ld |=> (cnt_q == CNT_W'(LMAX) && cls_q == $past(ld_cls)));

   // R6: an entry is live exactly while its counter runs
   p_live_consistent_r6 : assert property (@(posedge clk) disable iff (rst)
      (cls_q == PC_NONE) == (cnt_q == '0));

endmodule

// File: rtl/ilk_src_check.sv
module ilk_src_check
   import ilk_pkg::*;
#(
   parameter int REG_W     = 6,
   parameter int NREGS     = 64,
   parameter int CNT_W     = 2,
   parameter int LMAX      = 3,
   parameter int LAT_FA_FA = 3,
   parameter int LAT_FA_SD = 2,
   parameter int LAT_LD_FA = 1,
   parameter int LAT_LD_SD = 0,
   parameter int LAT_LD_IN = 1,
   parameter int LAT_IN_IN = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [REG_W-1:0] idx,
   input  cons_cls_e        cons,
   input  prod_cls_e        ent_cls [NREGS],
   input  logic [CNT_W-1:0] ent_cnt [NREGS],
   output logic             haz
);

   function automatic int gap(input prod_cls_e p, input cons_cls_e c);
      int g;
      g = 0;
      case (p)
         PC_FPALU: begin
            if (c == CC_FPALU)       g = LAT_FA_FA;
            else if (c == CC_STDATA) g = LAT_FA_SD;
         end
         PC_LOAD: begin
            if (c == CC_FPALU)       g = LAT_LD_FA;
            else if (c == CC_STDATA) g = LAT_LD_SD;
            else                     g = LAT_LD_IN;
         end
         PC_INT: begin
            if (c == CC_INT || c == CC_BRANCH) g = LAT_IN_IN;
         end
         default: g = 0;
      endcase
      return g;
   endfunction

   prod_cls_e        sel_cls;
   logic [CNT_W-1:0] sel_cnt;
   int               slack;

   always_comb begin
      sel_cls = ent_cls[idx];
      sel_cnt = ent_cnt[idx];
      slack   = LMAX - gap(sel_cls, cons);
      haz     = en && (sel_cls != PC_NONE) && (int'(sel_cnt) > slack);
   end

   // R9: a hazard needs an enabled operand naming a live entry
   p_haz_live_r9 : assert property (@(posedge clk) disable iff (rst)
      haz |-> (en && ent_cls[idx] != PC_NONE && ent_cnt[idx] != '0));

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
   import ilk_pkg::*;
#(
   parameter int REG_W     = 6,
   parameter int NSRC      = 2,
   parameter int LAT_FA_FA = 3,
   parameter int LAT_FA_SD = 2,
   parameter int LAT_LD_FA = 1,
   parameter int LAT_LD_SD = 0,
   parameter int LAT_LD_IN = 1,
   parameter int LAT_IN_IN = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    iss_valid,
   input  logic [NSRC-1:0]         iss_src_en,
   input  logic [NSRC*REG_W-1:0]   iss_src_reg,
   input  logic [2*NSRC-1:0]       iss_src_cls,
   input  logic                    iss_wr_en,
   input  logic [REG_W-1:0]        iss_dst,
   input  logic [1:0]              iss_dst_cls,
   output logic                    iss_stall
);

   localparam int NREGS = 1 << REG_W;
   localparam int LMAX  = imax(1, imax(imax(LAT_FA_FA, LAT_FA_SD),
                               imax(imax(LAT_LD_FA, LAT_LD_SD),
                                    imax(LAT_LD_IN, LAT_IN_IN))));
   localparam int CNT_W = $clog2(LMAX + 1);
   localparam int RUN_W = CNT_W + 1;

   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("ilk_interlock: NSRC must be at least 1");
      end
      if (REG_W < 1 || REG_W > 10) begin : g_bad_regw
         $error("ilk_interlock: REG_W out of range");
      end
      if (LAT_FA_FA < 0 || LAT_FA_SD < 0 || LAT_LD_FA < 0 ||
          LAT_LD_SD < 0 || LAT_LD_IN < 0 || LAT_IN_IN < 0) begin : g_bad_lat
         $error("ilk_interlock: latencies must not be negative");
      end
   endgenerate

   prod_cls_e        ent_cls [NREGS];
   logic [CNT_W-1:0] ent_cnt [NREGS];
   logic [NSRC-1:0]  src_haz;
   logic             fire;

   assign iss_stall = iss_valid && (|src_haz);
   assign fire      = iss_valid && !(|src_haz);

   for (genvar g = 0; g < NREGS; g++) begin : g_ent
      logic ld;
      assign ld = fire && iss_wr_en && (iss_dst == REG_W'(g));
      ilk_sb_entry #(
         .CNT_W (CNT_W),
         .LMAX  (LMAX)
      ) u_ent (
         .clk    (clk),
         .rst    (rst),
         .ld     (ld),
         .ld_cls (prod_cls_e'(iss_dst_cls)),
         .cls_o  (ent_cls[g]),
         .cnt_o  (ent_cnt[g])
      );
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      ilk_src_check #(
         .REG_W     (REG_W),
         .NREGS     (NREGS),
         .CNT_W     (CNT_W),
         .LMAX      (LMAX),
         .LAT_FA_FA (LAT_FA_FA),
         .LAT_FA_SD (LAT_FA_SD),
         .LAT_LD_FA (LAT_LD_FA),
         .LAT_LD_SD (LAT_LD_SD),
         .LAT_LD_IN (LAT_LD_IN),
         .LAT_IN_IN (LAT_IN_IN)
      ) u_chk (
         .clk     (clk),
         .rst     (rst),
         .en      (iss_src_en[s]),
         .idx     (iss_src_reg[s*REG_W +: REG_W]),
         .cons    (cons_cls_e'(iss_src_cls[2*s +: 2])),
         .ent_cls (ent_cls),
         .ent_cnt (ent_cnt),
         .haz     (src_haz[s])
      );
   end

   // consecutive-stall counter used only by the drain check
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (rst)            run_q <= '0;
      else if (iss_stall) run_q <= run_q + 1'b1;
      else                run_q <= '0;
   end

   // R6: no new loads happen while stalled, so a stall drains within LMAX cycles
   p_stall_bounded_r6 : assert property (@(posedge clk) disable iff (rst)
      iss_stall |-> (run_q < RUN_W'(LMAX)));

   // R6: a stalled instruction leaves the destination entry untouched
   p_stall_no_load_r6 : assert property (@(posedge clk) disable iff (rst)
      (iss_stall && iss_wr_en) |=> (ent_cnt[$past(iss_dst)] != CNT_W'(LMAX) ||
                                    $past(ent_cnt[iss_dst]) == CNT_W'(LMAX)));

endmodule

// File: tb/sim_ilk_interlock.sv
`timescale 1ns/1ps
module sim_ilk_interlock;

   localparam int REG_W = 6;
   localparam int NSRC  = 2;
   localparam int GPR1 = 1, GPR2 = 2;
   localparam int F0 = 32, F2 = 34, F4 = 36, F6 = 38, F8 = 40, F10 = 42;
   localparam int P_FA = 1, P_LD = 2, P_IN = 3;
   localparam int C_FA = 0, C_SD = 1, C_IN = 2, C_BR = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic iss_valid = 1'b0;
   logic [NSRC-1:0] iss_src_en = '0;
   logic [NSRC*REG_W-1:0] iss_src_reg = '0;
   logic [2*NSRC-1:0] iss_src_cls = '0;
   logic iss_wr_en = 1'b0;
   logic [REG_W-1:0] iss_dst = '0;
   logic [1:0] iss_dst_cls = '0;
   logic iss_stall;

   always #4 clk = ~clk;

   ilk_interlock u0 (
      .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src_en(iss_src_en),
      .iss_src_reg(iss_src_reg), .iss_src_cls(iss_src_cls), .iss_wr_en(iss_wr_en),
      .iss_dst(iss_dst), .iss_dst_cls(iss_dst_cls), .iss_stall(iss_stall)
   );

   int checks = 0;
   int errors = 0;
   longint cyc = 0;
   int     m_cls [64];
   longint m_at  [64];

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int need(input int p, input int c);
      if (p == P_FA) return (c == C_FA) ? 3 : (c == C_SD) ? 2 : 0;
      if (p == P_LD) return (c == C_FA) ? 1 : (c == C_SD) ? 0 : 1;
      if (p == P_IN) return (c == C_IN || c == C_BR) ? 1 : 0;
      return 0;
   endfunction

   function automatic int ref_stall();
      int s = 0;
      if (!iss_valid) return 0;
      for (int i = 0; i < NSRC; i++) begin
         if (iss_src_en[i]) begin
            int r = int'(iss_src_reg[i*REG_W +: REG_W]);
            int c = int'(iss_src_cls[2*i +: 2]);
            if (m_cls[r] != 0 && (cyc - m_at[r]) <= longint'(need(m_cls[r], c))) s = 1;
         end
      end
      return s;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 64; i++) begin
         m_cls[i] = 0;
         m_at[i]  = 0;
      end
   endtask

   task automatic iss(input bit ena, input int ra, input int ca,
                      input bit enb, input int rb, input int cb,
                      input bit wen, input int dst, input int dcls,
                      output int stalls);
      bit done = 0;
      stalls = 0;
      iss_valid   = 1'b1;
      iss_src_en  = {enb, ena};
      iss_src_reg = {REG_W'(rb), REG_W'(ra)};
      iss_src_cls = {2'(cb), 2'(ca)};
      iss_wr_en   = wen;
      iss_dst     = REG_W'(dst);
      iss_dst_cls = 2'(dcls);
      while (!done) begin
         #1;
         chk("R6", "per-cycle stall vs model", int'(iss_stall), ref_stall());
         if (iss_stall) stalls++;
         else done = 1;
         @(posedge clk);
         if (done && wen) begin
            m_cls[dst] = dcls;
            m_at[dst]  = cyc;
         end
         cyc++;
         @(negedge clk);
      end
      iss_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      iss_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         #1;
         chk("R9", "idle stall vs model", int'(iss_stall), ref_stall());
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      cyc++;
      model_clear();
      @(negedge clk);
      rst = 1'b0;
   endtask

   // instruction helpers; each returns the stall count
   task automatic i_ld(input int d, input int base, output int s);
      iss(1, base, C_IN, 0, 0, 0, 1, d, P_LD, s);
   endtask
   task automatic i_fadd(input int d, input int a, input int b, output int s);
      iss(1, a, C_FA, 1, b, C_FA, 1, d, P_FA, s);
   endtask
   task automatic i_sd(input int data, input int base, output int s);
      iss(1, base, C_IN, 1, data, C_SD, 0, 0, 0, s);
   endtask
   task automatic i_subi(input int d, input int a, output int s);
      iss(1, a, C_IN, 0, 0, 0, 1, d, P_IN, s);
   endtask
   task automatic i_bnez(input int a, output int s);
      iss(1, a, C_BR, 0, 0, 0, 0, 0, 0, s);
   endtask
   task automatic i_nop(output int s);
      iss(0, 0, 0, 0, 0, 0, 0, 0, 0, s);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int s, tot;
      model_clear();
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R8", "stall after reset", int'(iss_stall), 0);
      @(negedge clk);

      // R1: FP ALU -> FP ALU
      i_fadd(F4, F0, F2, s);
      i_fadd(F6, F4, F2, s);
      chk("R1", "fp->fp stalls", s, 3);
      idle(4);

      // R2: FP ALU -> store data
      i_fadd(F4, F0, F2, s);
      i_sd(F4, GPR1, s);
      chk("R2", "fp->store stalls", s, 2);
      idle(4);

      // R3: load -> FP ALU and load -> branch
      i_ld(F0, GPR1, s);
      i_fadd(F4, F0, F2, s);
      chk("R3", "load->fp stalls", s, 1);
      i_ld(GPR2, GPR1, s);
      i_bnez(GPR2, s);
      chk("R3", "load->branch stalls", s, 1);
      idle(4);

      // R4: load -> store data
      i_ld(F0, GPR1, s);
      i_sd(F0, GPR1, s);
      chk("R4", "load->store stalls", s, 0);
      idle(4);

      // R5: integer -> integer and integer -> branch
      i_subi(GPR1, GPR1, s);
      i_subi(GPR2, GPR1, s);
      chk("R5", "int->int stalls", s, 1);
      i_bnez(GPR2, s);
      chk("R5", "int->branch stalls", s, 1);
      idle(4);

      // R6: both sources in flight, later one decides
      i_fadd(F2, F0, F0, s);
      i_ld(F6, GPR1, s);
      i_fadd(F8, F6, F2, s);
      chk("R6", "two-source stalls", s, 2);
      idle(4);

      // R7: faster rewrite replaces slower entry
      i_fadd(F8, F0, F2, s);
      i_ld(F8, GPR1, s);
      i_fadd(F10, F8, F2, s);
      chk("R7", "replaced entry stalls", s, 1);
      idle(4);

      // R9: disabled operand naming a busy register
      i_fadd(F4, F0, F2, s);
      iss(0, F4, C_FA, 1, F0, C_FA, 1, F10, P_FA, s);
      chk("R9", "disabled operand stalls", s, 0);
      idle(4);

      // R11: unlisted pairs
      i_fadd(F8, F0, F2, s);
      iss(1, F8, C_IN, 0, 0, 0, 0, 0, 0, s);
      chk("R11", "fp->int stalls", s, 0);
      i_subi(GPR2, GPR1, s);
      iss(1, GPR2, C_SD, 0, 0, 0, 0, 0, 0, s);
      chk("R11", "int->store stalls", s, 0);
      idle(4);

      // R8: reset in the middle of a hazard
      i_fadd(F4, F0, F2, s);
      do_reset();
      i_fadd(F10, F4, F2, s);
      chk("R8", "stalls after reset", s, 0);
      idle(4);

      // R10: unscheduled loop
      for (int it = 0; it < 3; it++) begin
         tot = 0;
         i_ld(F0, GPR1, s);       tot += 1 + s;
         i_fadd(F4, F0, F2, s);   tot += 1 + s;
         i_sd(F4, GPR1, s);       tot += 1 + s;
         i_subi(GPR1, GPR1, s);   tot += 1 + s;
         i_bnez(GPR1, s);         tot += 1 + s;
         i_nop(s);                tot += 1 + s;
         chk("R10", "unscheduled cycles per iteration", tot, 10);
      end
      idle(4);

      // R10: rescheduled loop, store in delay slot
      for (int it = 0; it < 3; it++) begin
         tot = 0;
         i_ld(F0, GPR1, s);       tot += 1 + s;
         i_subi(GPR1, GPR1, s);   tot += 1 + s;
         i_fadd(F4, F0, F2, s);   tot += 1 + s;
         i_bnez(GPR1, s);         tot += 1 + s;
         i_sd(F4, GPR1, s);       tot += 1 + s;
         chk("R10", "rescheduled cycles per iteration", tot, 6);
      end
      idle(4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule